// File: doc/BRIEF.md
# CAN Receive Ping-Pong Buffer

This block is the receive store of a CAN controller. It has two message buffers of equal size. One is the background buffer, which only the receive engine writes. The other is the foreground buffer, which the CPU reads through one fixed byte window. The two physical buffers swap these roles as frames arrive, so together they act as a two-entry input queue. The CPU always reads from the same addresses, whichever physical buffer is foreground at the time.

The receive engine writes the bytes of a frame into the background buffer. Each buffer holds 13 bytes: control bits, a standard or extended identifier, and the payload. The engine then pulses a frame-complete strobe with an accepted bit. A completed frame whose identifier passed filtering becomes visible to the CPU, and a full flag goes up. The CPU clears that flag by writing 1 to it. If a second accepted frame arrives while the flag is still set, it is parked in the background buffer. If a third arrives while one is parked, it is lost and a sticky overrun flag is raised.

Top module: `can_rx_pingpong`

## Requirements
- R1: After reset, the full flag and the overrun flag are 0, physical buffer 0 is foreground, and every foreground byte reads 0.
- R2: A frame-complete strobe with the accepted bit at 1, while the full flag is 0 and no frame is parked, swaps the buffers and sets the full flag on the same clock edge. The new foreground then returns the bytes the engine wrote.
- R3: A frame-complete strobe with the accepted bit at 0 changes neither flag nor the foreground contents. The same holds for an aborted frame, which ends with no strobe at all.
- R4: The CPU read port returns foreground byte N for addresses 0 to 12, and returns 0 for any address of 13 or above.
- R5: An accepted frame that completes while the full flag is 1 and nothing is parked is parked in the background buffer. The foreground and the full flag stay as they are.
- R6: A pulse on the clear-full input drops the full flag on that edge. If a frame is parked, the buffers swap and the full flag is set again on the following edge.
- R7: While a frame is parked, writes from the engine are ignored. A further accepted frame raises the overrun flag and is discarded. The parked frame and the foreground are left intact.
- R8: A pulse on the clear-overrun input returns the overrun flag to 0 when no new overrun occurs on the same edge.
- R9: The overrun flag stays at 1 until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Engine byte-write enable |
| wrAddr | input | 4 | Engine byte index within the background buffer |
| wrData | input | 8 | Engine byte data |
| frameDone | input | 1 | One-cycle strobe: the frame is complete |
| frameAccepted | input | 1 | Qualifies frameDone: the identifier passed filtering |
| cpuRdAddr | input | 4 | CPU byte index within the foreground window |
| cpuRdData | output | 8 | Foreground byte (combinational) |
| clearFull | input | 1 | CPU write-1 pulse that clears the full flag |
| clearOverrun | input | 1 | CPU write-1 pulse that clears the overrun flag |
| fullFlag | output | 1 | The foreground holds an unread accepted frame |
| overrun | output | 1 | An accepted frame was lost |

## Verification
A vector table runs a sequence of frames through every combination of flag state and acceptance:
- an accepted frame into an empty store;
- a rejected frame while the store is full;
- a frame parked behind the foreground;
- a frame lost to overrun and then released by a clear;
- a rejected frame followed by a clear that leaves the store empty.

Each frame has its own byte pattern, so a read-back tells which frame reached the foreground and shows any bytes that were overwritten.

Directed tests then sample single cycles to check the timing:
- that the swap and the flag set happen on the same edge;
- that a parked frame is promoted exactly one edge after the clear;
- that writes to a parked buffer are blocked, shown by a later frame's bytes failing to appear after promotion.

// File: rtl/rx_pp_pkg.sv
package rx_pp_pkg;
  typedef struct packed {
    logic swap;    // exchange foreground and background roles
    logic bgWrEn;  // engine write may land in the background buffer
  } ppCtl_t;
endpackage

// File: rtl/rx_pp_ctrl.sv
module rx_pp_ctrl
  import rx_pp_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrEn,
  input  logic   frameDone,
  input  logic   frameAccepted,
  input  logic   clearFull,
  input  logic   clearOverrun,
  output ppCtl_t ctl,
  output logic   fullFlag,
  output logic   overrun,
  output logic   pending
);
  logic accDone, promote, directSwap, parkFrame, lostFrame;

  always_comb begin
    accDone    = frameDone & frameAccepted;
    promote    = ~fullFlag & pending;
    directSwap = accDone & ~fullFlag & ~pending;
    parkFrame  = accDone & fullFlag & ~pending;
    // A parked frame blocks writes, so any accepted frame seen while one is
    // parked (including the promote cycle) has nowhere to live.
    lostFrame  = accDone & pending;
    ctl.swap   = promote | directSwap;
    ctl.bgWrEn = wrEn & ~pending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag <= 1'b0;
      pending  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (ctl.swap)       fullFlag <= 1'b1;
      else if (clearFull) fullFlag <= 1'b0;

      if (promote)        pending <= 1'b0;
      else if (parkFrame) pending <= 1'b1;

      if (lostFrame)         overrun <= 1'b1;
      else if (clearOverrun) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_pp_datapath.sv
module rx_pp_datapath
  import rx_pp_pkg::*;
#(
  parameter int NBYTES = 13,
  parameter int DW     = 8,
  localparam int AW    = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ppCtl_t        ctl,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] cpuRdAddr,
  output logic [DW-1:0] cpuRdData,
  output logic          fgSel
);
  localparam int NBANKS = 2;

  logic [DW-1:0] bank [NBANKS][NBYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         fgSel <= 1'b0;
    else if (ctl.swap) fgSel <= ~fgSel;
  end

  for (genvar b = 0; b < NBANKS; b++) begin : gBank
    logic bankWr;
    assign bankWr = ctl.bgWrEn && (fgSel != 1'(b)) && (int'(wrAddr) < NBYTES);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NBYTES; i++) bank[b][i] <= '0;
      end else if (bankWr) begin
        bank[b][wrAddr] <= wrData;
      end
    end
  end

  always_comb begin
    cpuRdData = '0;
    if (int'(cpuRdAddr) < NBYTES) cpuRdData = bank[fgSel][cpuRdAddr];
  end
endmodule

// File: rtl/can_rx_pingpong.sv
module can_rx_pingpong
  import rx_pp_pkg::*;
#(
  parameter int NBYTES = 13,
  parameter int DW     = 8,
  localparam int AW    = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          frameDone,
  input  logic          frameAccepted,
  input  logic [AW-1:0] cpuRdAddr,
  output logic [DW-1:0] cpuRdData,
  input  logic          clearFull,
  input  logic          clearOverrun,
  output logic          fullFlag,
  output logic          overrun
);
  ppCtl_t ctl;
  logic   pendingFlag;
  logic   fgSel;

  rx_pp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .frameDone(frameDone), .frameAccepted(frameAccepted),
    .clearFull(clearFull), .clearOverrun(clearOverrun),
    .ctl(ctl), .fullFlag(fullFlag), .overrun(overrun), .pending(pendingFlag)
  );

  rx_pp_datapath #(.NBYTES(NBYTES), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrAddr(wrAddr), .wrData(wrData),
    .cpuRdAddr(cpuRdAddr), .cpuRdData(cpuRdData), .fgSel(fgSel)
  );
endmodule

// File: rtl/can_rx_pingpong_checker.sv
module can_rx_pingpong_checker (
  input logic clk,
  input logic rstN,
  input logic frameDone,
  input logic frameAccepted,
  input logic clearFull,
  input logic clearOverrun,
  input logic fullFlag,
  input logic overrun,
  input logic pendingFlag,
  input logic fgSel
);
  AST_ACCEPT_SETS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && frameAccepted && !fullFlag && !pendingFlag |=> fullFlag && (fgSel != $past(fgSel))); // R2
  AST_REJECT_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !frameAccepted && fullFlag && !clearFull |=> fullFlag && $stable(fgSel)); // R3
  AST_REJECT_KEEPS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !frameAccepted && !fullFlag && !pendingFlag |=> !fullFlag && $stable(fgSel)); // R3
  AST_FULL_HOLDS_FG: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag && !clearFull |=> $stable(fgSel) && fullFlag); // R5
  AST_CLEAR_DROPS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    clearFull && fullFlag |=> !fullFlag); // R6
  AST_PARKED_PROMOTES: assert property (@(posedge clk) disable iff (!rstN)
    !fullFlag && pendingFlag |=> fullFlag && !pendingFlag); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && frameAccepted && pendingFlag |=> overrun); // R7
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    clearOverrun && !frameDone |=> !overrun); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !clearOverrun |=> overrun); // R9
endmodule

bind can_rx_pingpong can_rx_pingpong_checker u_chk (
  .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameAccepted(frameAccepted),
  .clearFull(clearFull), .clearOverrun(clearOverrun), .fullFlag(fullFlag),
  .overrun(overrun), .pendingFlag(pendingFlag), .fgSel(fgSel)
);

// File: tb/can_rx_pingpong_tb.sv
`timescale 1ns/100ps
module can_rx_pingpong_tb;
  localparam int NB = 13;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       frameDone = 1'b0;
  logic       frameAccepted = 1'b0;
  logic [3:0] cpuRdAddr = '0;
  logic [7:0] cpuRdData;
  logic       clearFull = 1'b0;
  logic       clearOverrun = 1'b0;
  logic       fullFlag;
  logic       overrun;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  can_rx_pingpong u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameDone(frameDone), .frameAccepted(frameAccepted),
    .cpuRdAddr(cpuRdAddr), .cpuRdData(cpuRdData),
    .clearFull(clearFull), .clearOverrun(clearOverrun),
    .fullFlag(fullFlag), .overrun(overrun)
  );

  typedef struct packed {
    logic [7:0] seed;
    logic       acc;
    logic       clr;
    logic       expFull;
    logic       expOvr;
    logic [7:0] expFg;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd10, 1'b1, 1'b0, 1'b1, 1'b0, 8'd10},  // R2 accepted into empty store
    '{8'd20, 1'b0, 1'b0, 1'b1, 1'b0, 8'd10},  // R3 rejected while full
    '{8'd30, 1'b1, 1'b0, 1'b1, 1'b0, 8'd10},  // R5 parked behind foreground
    '{8'd40, 1'b1, 1'b1, 1'b1, 1'b1, 8'd30},  // R7 lost, then R6 promotes parked
    '{8'd50, 1'b1, 1'b1, 1'b1, 1'b1, 8'd50},  // R5 park + R6 promote, R9 sticky
    '{8'd60, 1'b0, 1'b1, 1'b0, 1'b1, 8'd50}   // R3 rejected, clear empties store
  };

  function automatic logic [7:0] patByte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Compares flags and the whole foreground window against a frame pattern.
  task automatic checkState(input string req, input logic eFull, input logic eOvr,
                            input logic [7:0] seed, input bit zeros);
    int bad = 0;
    logic [7:0] exp;
    check({req, " full"}, 32'(fullFlag), 32'(eFull));
    check({req, " overrun"}, 32'(overrun), 32'(eOvr));
    for (int i = 0; i < NB; i++) begin
      cpuRdAddr = 4'(i);
      #0.1;
      exp = zeros ? 8'd0 : patByte(seed, i);
      if (cpuRdData !== exp) begin
        if (bad == 0) $display("FAIL %s byte %0d: actual %0d expected %0d", req, i, cpuRdData, exp);
        bad++;
      end
    end
    nChecks++;
    if (bad != 0) nFails++;
  endtask

  task automatic writeFrame(input logic [7:0] seed, input logic acc);
    for (int i = 0; i < NB; i++) begin
      wrEn = 1'b1; wrAddr = 4'(i); wrData = patByte(seed, i);
      @(negedge clk);
    end
    wrEn = 1'b0;
    frameDone = 1'b1; frameAccepted = acc;
    @(negedge clk);
    frameDone = 1'b0; frameAccepted = 1'b0;
  endtask

  task automatic pulseClear();
    clearFull = 1'b1;
    @(negedge clk);
    clearFull = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 reset", 1'b0, 1'b0, 8'd0, 1'b1);

    // Aborted frame: bytes written, no strobe
    for (int i = 0; i < NB; i++) begin
      wrEn = 1'b1; wrAddr = 4'(i); wrData = 8'hEE;
      @(negedge clk);
    end
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
    checkState("R3 aborted", 1'b0, 1'b0, 8'd0, 1'b1);

    foreach (VECS[k]) begin
      writeFrame(VECS[k].seed, VECS[k].acc);
      if (VECS[k].clr) pulseClear();
      repeat (2) @(negedge clk);
      checkState($sformatf("R2/R3/R5/R6/R7 vec%0d", k), VECS[k].expFull,
                 VECS[k].expOvr, VECS[k].expFg, 1'b0);
    end

    // R8: clear overrun
    clearOverrun = 1'b1; @(negedge clk); clearOverrun = 1'b0;
    check("R8 overrun cleared", 32'(overrun), 32'd0);

    // R3: rejected while empty
    writeFrame(8'd80, 1'b0);
    repeat (2) @(negedge clk);
    checkState("R3 reject empty", 1'b0, 1'b0, 8'd50, 1'b0);

    // R2: swap and flag on the same edge as the strobe
    writeFrame(8'd90, 1'b1);
    checkState("R2 same edge", 1'b1, 1'b0, 8'd90, 1'b0);

    // R6: promotion one edge after the clear
    writeFrame(8'd100, 1'b1);
    clearFull = 1'b1; @(negedge clk); clearFull = 1'b0;
    check("R6 flag dropped", 32'(fullFlag), 32'd0);
    cpuRdAddr = 4'd0; #0.1;
    check("R6 fg not yet swapped", 32'(cpuRdData), 32'(patByte(8'd90, 0)));
    @(negedge clk);
    checkState("R6 promoted", 1'b1, 1'b0, 8'd100, 1'b0);

    // R4: out-of-window addresses
    cpuRdAddr = 4'd13; #0.1;
    check("R4 addr 13", 32'(cpuRdData), 32'd0);
    cpuRdAddr = 4'd15; #0.1;
    check("R4 addr 15", 32'(cpuRdData), 32'd0);

    // R7: writes blocked while a frame is parked
    writeFrame(8'd110, 1'b1);
    writeFrame(8'd120, 1'b0);
    pulseClear();
    repeat (2) @(negedge clk);
    checkState("R7 parked intact", 1'b1, 1'b0, 8'd110, 1'b0);

    // R9: overrun sticky across later traffic
    writeFrame(8'd130, 1'b1);
    writeFrame(8'd140, 1'b1);
    repeat (5) @(negedge clk);
    check("R9 overrun sticky", 32'(overrun), 32'd1);

    finished = 1;
    summary();
    $finish;
  end
endmodule